// File: doc/BRIEF.md
# Accumulator Controller Core

A compact 32-bit processor core for an embedded controller. It keeps all working data in a single accumulator and talks to one memory through one address bus and one pair of data buses, used for instruction words and data words alike. A state machine walks every instruction through fetch, decode and one or more execute states chosen by the opcode. Each state lasts one clock. After the last execute state the machine returns to fetch.

An instruction word carries an 8-bit opcode in bits 30:23 and a 23-bit operand in bits 22:0. Bit 31 is ignored. The operand is a memory address, a jump target or a shift amount, depending on the opcode. Arithmetic, logic and load results land in the accumulator, and so do shift and rotate results. Three registered status lines report whether the last result was zero, positive (nonzero with bit 31 clear) or negative (bit 31 set). The conditional jumps test these lines.

The instruction register captures the fetched word on the falling clock edge in the middle of the decode state. The decode logic therefore sees the new opcode before the next rising edge.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high the core stays in its reset state: `acc_value` = 0, `pc_value` = 0, `st_zero` = 1, and both strobes are low. The first rising edge with `rst` low enters fetch, so `bus_rd` = 1 with `bus_addr` = 0 in the next cycle.
- R2: Opcode = word[30:23] and operand = word[22:0]. Bit 31 has no effect on execution.
- R3: Fetch (`bus_rd` high, address = PC) is followed by exactly one decode cycle with both strobes low. Execute length depends on the opcode:
  - Memory-operand instructions take a read cycle (`bus_rd` high, address = operand) and then a result cycle, for 4 clocks in total.
  - STA, shifts and jumps take 3 clocks.
  - NOP takes 2 clocks.
  - `bus_rd` and `bus_wr` are never high together.
- R4: The PC increments by one at each fetch. A taken jump loads the operand into the PC.
- R5: The arithmetic opcodes use the memory word at the operand address as B and the accumulator as A. Results are taken modulo 2^32. 0x01 gives A+B, 0x02 gives A−B, 0x03 gives the low 32 bits of A×B.
- R6: 0x04 gives the unsigned quotient A/B. When B = 0 the accumulator becomes 0xFFFFFFFF, and the next fetch follows on schedule.
- R7: 0x05 gives A AND B, 0x06 gives A OR B, 0x07 gives A XOR B.
- R8: 0x08 (compare) sets the status lines from A−B and leaves the accumulator unchanged.
- R9: Shifts and rotate operate on the accumulator.
  - 0x09 shifts left by one.
  - 0x0A shifts right by one, logical.
  - 0x0B rotates left by operand[4:0] positions.
- R10: 0x10 loads the memory word at the operand address. 0x11 writes the accumulator to that address.
- R11: Jumps load the operand into the PC.
  - 0x12 always jumps.
  - 0x13 jumps only when zero status is set.
  - 0x14 jumps only when negative status is set.
- R12: Every accumulator write updates the status: zero when the value is 0, negative when bit 31 is set, positive otherwise. Exactly one status line is high at any time.
- R13: Opcode 0x00 and every unassigned opcode leave the accumulator, the status and memory untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state on rising edge, instruction register on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 23 | Shared memory address |
| bus_rd | output | 1 | Read strobe; data returns one cycle later |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 32 | Write data (accumulator) |
| bus_rdata | input | 32 | Read data |
| acc_value | output | 32 | Accumulator contents |
| pc_value | output | 23 | Program counter |
| st_zero | output | 1 | Status: last result zero |
| st_pos | output | 1 | Status: last result positive |
| st_neg | output | 1 | Status: last result negative |

## Verification
Every two-operand opcode is swept over the full cross product of eight operand values. The values are zero, one, two, a small odd number, the largest positive, the sign bit alone, all ones and a mixed pattern. This separates wrap-around from saturation, signed from unsigned readings of the status, divide by zero from ordinary division, and compare from subtract.

The rotate is swept over all 32 amounts. This shows the amount is taken from the operand, and that amounts 0 and 31 wrap correctly.

Each jump runs on every value, so the taken and not-taken paths show up in which word ends up in the accumulator.

A strobe trace checked cycle by cycle after reset release shows:
- the per-class instruction lengths;
- the read latency;
- that the PC advances at each fetch.

Alternate runs set the unused top instruction bit. Unassigned opcodes are mixed in between a load and a store, which exposes any stray effect.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_FETCH,
        ST_DECODE,
        ST_MEM_RD,
        ST_ALU,
        ST_STORE,
        ST_SHIFT,
        ST_BRANCH
    } state_e;

    typedef enum logic [4:0] {
        OP_NOP, OP_ADD, OP_SUB, OP_MUL, OP_DIV,
        OP_AND, OP_OR, OP_XOR, OP_CMP,
        OP_SHL, OP_SHR, OP_ROL,
        OP_LDA, OP_STA, OP_JMP, OP_JZ, OP_JN
    } op_e;

    function automatic op_e decode_op(input logic [OPC_W-1:0] code);
        case (code)
            8'h01:   return OP_ADD;
            8'h02:   return OP_SUB;
            8'h03:   return OP_MUL;
            8'h04:   return OP_DIV;
            8'h05:   return OP_AND;
            8'h06:   return OP_OR;
            8'h07:   return OP_XOR;
            8'h08:   return OP_CMP;
            8'h09:   return OP_SHL;
            8'h0A:   return OP_SHR;
            8'h0B:   return OP_ROL;
            8'h10:   return OP_LDA;
            8'h11:   return OP_STA;
            8'h12:   return OP_JMP;
            8'h13:   return OP_JZ;
            8'h14:   return OP_JN;
            default: return OP_NOP;
        endcase
    endfunction

    // Which execute path an operation takes after decode.
    function automatic state_e exec_entry(input op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_AND, OP_OR,
            OP_XOR, OP_CMP, OP_LDA:       return ST_MEM_RD;
            OP_STA:                       return ST_STORE;
            OP_SHL, OP_SHR, OP_ROL:       return ST_SHIFT;
            OP_JMP, OP_JZ, OP_JN:         return ST_BRANCH;
            default:                      return ST_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/acc_ir.sv
module acc_ir
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] word_i,
    output logic [OPC_W-1:0]  opcode_o,
    output logic [ADDR_W-1:0] operand_o
);
    localparam int FIELD_W = OPC_W + ADDR_W;

    logic [FIELD_W-1:0] ir_d, ir_q;
    logic               unused_top_bits;

    assign unused_top_bits = ^word_i[DATA_W-1:FIELD_W];

    always_comb begin
        ir_d = ir_q;
        if (load) begin
            ir_d = word_i[FIELD_W-1:0];
        end
    end

    // Falling-edge capture: the opcode is stable for the second half of decode.
    always_ff @(negedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign opcode_o  = ir_q[FIELD_W-1:ADDR_W];
    assign operand_o = ir_q[ADDR_W-1:0];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  op_e                op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [SHAMT_W-1:0] amt,
    output logic [DATA_W-1:0]  result,
    output logic [DATA_W-1:0]  flag_src
);
    logic [2*DATA_W-1:0] rot_wide;

    assign rot_wide = {a, a} << amt;

    always_comb begin
        result = a;
        case (op)
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_MUL:  result = a * b;
            OP_DIV:  result = (b == '0) ? '1 : a / b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_SHL:  result = {a[DATA_W-2:0], 1'b0};
            OP_SHR:  result = {1'b0, a[DATA_W-1:1]};
            OP_ROL:  result = rot_wide[2*DATA_W-1 -: DATA_W];
            OP_LDA:  result = b;
            default: result = a;
        endcase
        flag_src = (op == OP_CMP) ? (a - b) : result;
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] acc_value,
    output logic [ADDR_W-1:0] pc_value,
    output logic              st_zero,
    output logic              st_pos,
    output logic              st_neg
);
    localparam int SHAMT_W = $clog2(DATA_W);

    typedef struct packed {
        state_e              state;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   acc;
        logic                zero;
        logic                neg;
    } core_t;

    localparam core_t CORE_RESET = '{
        state: ST_RESET, pc: '0, acc: '0, zero: 1'b1, neg: 1'b0
    };

    core_t cur_q, nxt_d;

    logic [OPC_W-1:0]   ir_opcode;
    logic [ADDR_W-1:0]  ir_operand;
    logic               ir_load;
    op_e                op;
    logic [DATA_W-1:0]  alu_result, alu_flag_src;
    logic               take_jump;

    acc_ir #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ir (
        .clk       (clk),
        .rst       (rst),
        .load      (ir_load),
        .word_i    (bus_rdata),
        .opcode_o  (ir_opcode),
        .operand_o (ir_operand)
    );

    assign op = decode_op(ir_opcode);

    acc_alu #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_alu (
        .op       (op),
        .a        (cur_q.acc),
        .b        (bus_rdata),
        .amt      (ir_operand[SHAMT_W-1:0]),
        .result   (alu_result),
        .flag_src (alu_flag_src)
    );

    assign take_jump = (op == OP_JMP)
                    || (op == OP_JZ && cur_q.zero)
                    || (op == OP_JN && cur_q.neg);

    always_comb begin
        nxt_d     = cur_q;
        bus_addr  = cur_q.pc;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = cur_q.acc;
        ir_load   = 1'b0;
        case (cur_q.state)
            ST_RESET: begin
                nxt_d.state = ST_FETCH;
            end
            ST_FETCH: begin
                bus_rd      = 1'b1;
                nxt_d.pc    = cur_q.pc + 1'b1;
                nxt_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                ir_load     = 1'b1;
                nxt_d.state = exec_entry(op);
            end
            ST_MEM_RD: begin
                bus_rd      = 1'b1;
                bus_addr    = ir_operand;
                nxt_d.state = ST_ALU;
            end
            ST_ALU, ST_SHIFT: begin
                if (op != OP_CMP) begin
                    nxt_d.acc = alu_result;
                end
                nxt_d.zero  = (alu_flag_src == '0);
                nxt_d.neg   = alu_flag_src[DATA_W-1];
                nxt_d.state = ST_FETCH;
            end
            ST_STORE: begin
                bus_wr      = 1'b1;
                bus_addr    = ir_operand;
                nxt_d.state = ST_FETCH;
            end
            ST_BRANCH: begin
                if (take_jump) begin
                    nxt_d.pc = ir_operand;
                end
                nxt_d.state = ST_FETCH;
            end
            default: nxt_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= CORE_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign acc_value = cur_q.acc;
    assign pc_value  = cur_q.pc;
    assign st_zero   = cur_q.zero;
    assign st_neg    = cur_q.neg;
    assign st_pos    = !cur_q.zero && !cur_q.neg;

    // R1: leaving reset always goes to fetch
    p_leave_reset_r1: assert property (@(posedge clk) disable iff (rst)
        cur_q.state == ST_RESET |=> cur_q.state == ST_FETCH);

    // R3: decode directly follows fetch; strobes never overlap
    p_decode_follows_r3: assert property (@(posedge clk) disable iff (rst)
        cur_q.state == ST_FETCH |=> cur_q.state == ST_DECODE);
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R4: fetch advances the program counter by one
    p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
        cur_q.state == ST_FETCH |=> cur_q.pc == $past(cur_q.pc) + 1'b1);

    // R6: divide by zero saturates the accumulator
    p_div_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_ALU && op == OP_DIV && bus_rdata == '0)
        |=> cur_q.acc == '1);

    // R8: compare leaves the accumulator alone
    p_cmp_keeps_acc_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_ALU && op == OP_CMP) |=> $stable(cur_q.acc));

    // R12: exactly one status line active
    p_status_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $countones({st_zero, st_pos, st_neg}) == 1);

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [22:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [31:0] acc_value;
    logic [22:0] pc_value;
    logic        st_zero, st_pos, st_neg;

    logic [31:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_a = '0;
    logic [31:0] ld_d = '0;
    logic [31:0] vals [8];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    acc_core dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .acc_value(acc_value), .pc_value(pc_value),
        .st_zero(st_zero), .st_pos(st_pos), .st_neg(st_neg)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_a] <= ld_d;
        else if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
        if (bus_rd) bus_rdata <= mem[bus_addr[7:0]];
    end

    function automatic logic [31:0] ins(input logic [7:0] opc, input logic [22:0] opd,
                                        input bit top);
        return {top, opc, opd};
    endfunction

    function automatic logic [31:0] model(input logic [7:0] opc, input logic [31:0] x,
                                          input logic [31:0] y);
        int s;
        case (opc)
            8'h01: return x + y;
            8'h02: return x - y;
            8'h03: return x * y;
            8'h04: return (y == 0) ? 32'hFFFF_FFFF : x / y;
            8'h05: return x & y;
            8'h06: return x | y;
            8'h07: return x ^ y;
            8'h09: return x * 2;
            8'h0A: return x / 2;
            8'h0B: begin
                s = int'(y[4:0]);
                return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
            end
            default: return x;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_status(input string req, input logic [31:0] v);
        chk({req, " R12 zero"}, {31'b0, st_zero}, {31'b0, v == 0});
        chk({req, " R12 neg"},  {31'b0, st_neg},  {31'b0, v[31]});
        chk({req, " R12 pos"},  {31'b0, st_pos},  {31'b0, v != 0 && !v[31]});
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input int n);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // LDA x; OP y; STA; halt
    task automatic two_op(input logic [7:0] opc, input logic [31:0] x,
                          input logic [31:0] y, input bit top, input string req);
        logic [31:0] e, f;
        string tag;
        hold_reset();
        poke(0, ins(8'h10, 23'd100, 1'b0));
        if (opc >= 8'h09 && opc <= 8'h0B) poke(1, ins(opc, y[22:0], top));
        else poke(1, ins(opc, 23'd101, top));
        poke(2, ins(8'h11, 23'd102, 1'b0));
        poke(3, ins(8'h12, 23'd3, 1'b0));
        poke(100, x); poke(101, y); poke(102, 32'hDEAD_BEEF);
        run(25);
        e = model(opc, x, y);
        f = (opc == 8'h08) ? x - y : e;
        tag = top ? {req, " R2"} : req;
        chk({tag, " acc"}, acc_value, e);
        chk({tag, " R10 stored"}, mem[102], e);
        chk_status(tag, f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h2; vals[3] = 32'h7;
        vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h8000_0000; vals[6] = 32'hFFFF_FFFF;
        vals[7] = 32'h1234_5678;
        repeat (3) @(negedge clk);

        // R5 R6 R7 R8: full cross product
        for (int o = 1; o <= 8; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    string req;
                    req = (o <= 3) ? "R5" : (o == 4) ? "R6" : (o <= 7) ? "R7" : "R8";
                    two_op(8'(o), vals[i], vals[j], bit'(j % 2), req);
                end
            end
        end
        // R9: shifts by one, rotate over every amount
        for (int i = 0; i < 8; i++) begin
            two_op(8'h09, vals[i], 32'd5, 1'b0, "R9 shl");
            two_op(8'h0A, vals[i], 32'd5, 1'b1, "R9 shr");
            for (int s = 0; s < 32; s++) two_op(8'h0B, vals[i], 32'(s), bit'(s % 2), "R9 rol");
        end
        // R11: jumps, taken path lands 0xBBBB, fall-through 0xAAAA
        for (int i = 0; i < 8; i++) begin
            for (int o = 8'h12; o <= 8'h14; o++) begin
                bit taken;
                hold_reset();
                poke(0, ins(8'h10, 23'd100, 1'b0));
                poke(1, ins(8'(o), 23'd6, 1'b0));
                poke(2, ins(8'h10, 23'd101, 1'b0));
                poke(3, ins(8'h12, 23'd3, 1'b0));
                poke(6, ins(8'h10, 23'd102, 1'b0));
                poke(7, ins(8'h12, 23'd7, 1'b0));
                poke(100, vals[i]); poke(101, 32'hAAAA); poke(102, 32'hBBBB);
                run(25);
                taken = (o == 8'h12) || (o == 8'h13 && vals[i] == 0)
                     || (o == 8'h14 && vals[i][31]);
                chk("R11 R4 jump target", acc_value, taken ? 32'hBBBB : 32'hAAAA);
            end
        end
        // R13: no-op and unassigned opcodes between load and store
        for (int i = 0; i < 8; i++) begin
            hold_reset();
            poke(0, ins(8'h10, 23'd100, 1'b0));
            poke(1, ins(8'h0C, 23'd101, 1'b0));
            poke(2, ins(8'h00, 23'd101, 1'b0));
            poke(3, ins(8'hFF, 23'd101, 1'b1));
            poke(4, ins(8'h15, 23'd101, 1'b0));
            poke(5, ins(8'h11, 23'd102, 1'b0));
            poke(6, ins(8'h12, 23'd6, 1'b0));
            poke(100, vals[i]); poke(101, 32'h5555_0000); poke(102, 32'hDEAD_BEEF);
            run(30);
            chk("R13 acc", acc_value, vals[i]);
            chk("R13 stored", mem[102], vals[i]);
            chk("R13 memory untouched", mem[101], 32'h5555_0000);
            chk_status("R13", vals[i]);
        end
        // R1 R3 R4: reset state and cycle-by-cycle strobe trace
        hold_reset();
        poke(0, ins(8'h10, 23'd100, 1'b0));
        poke(1, ins(8'h11, 23'd102, 1'b0));
        poke(2, ins(8'h00, 23'd0, 1'b0));
        poke(3, ins(8'h12, 23'd3, 1'b0));
        poke(100, 32'hC0DE_0042); poke(102, 32'h0);
        chk("R1 acc in reset", acc_value, 32'h0);
        chk("R1 pc in reset", {9'b0, pc_value}, 32'h0);
        chk("R1 zero in reset", {31'b0, st_zero}, 32'h1);
        chk("R1 strobes in reset", {30'b0, bus_rd, bus_wr}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first fetch", {bus_rd, bus_wr, 7'b0, bus_addr}, {2'b10, 30'd0});
        @(negedge clk);
        chk("R3 decode quiet", {30'b0, bus_rd, bus_wr}, 32'h0);
        chk("R4 pc after fetch", {9'b0, pc_value}, 32'd1);
        @(negedge clk);
        chk("R3 operand read", {bus_rd, bus_wr, 7'b0, bus_addr}, {2'b10, 30'd100});
        @(negedge clk);
        chk("R3 result cycle", {30'b0, bus_rd, bus_wr}, 32'h0);
        @(negedge clk);
        chk("R3 R4 second fetch", {bus_rd, bus_wr, 7'b0, bus_addr}, {2'b10, 30'd1});
        chk("R10 loaded", acc_value, 32'hC0DE_0042);
        @(negedge clk);
        @(negedge clk);
        chk("R3 store", {bus_rd, bus_wr, 7'b0, bus_addr}, {2'b01, 30'd102});
        chk("R10 store data", bus_wdata, 32'hC0DE_0042);
        @(negedge clk);
        chk("R3 third fetch", {bus_rd, bus_wr, 7'b0, bus_addr}, {2'b10, 30'd2});
        @(negedge clk);
        @(negedge clk);
        chk("R3 nop two clocks", {bus_rd, bus_wr, 7'b0, bus_addr}, {2'b10, 30'd3});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule